// File: doc/BRIEF.md
# Double-Data-Rate to Byte-Wide Ethernet Media Interface Bridge

This block sits between a gigabit Ethernet MAC that speaks the 8-bit, single-data-rate media-independent interface and a PHY that uses the reduced, double-data-rate variant. That variant has four data wires and one control wire per direction. On the transmit side the bridge takes one byte per rising edge and sends it as two nibbles, the low nibble while the clock is high and the high nibble while it is low. Its control wire carries the transmit enable in the high phase and the transmit error in the low phase. On the receive side it captures one nibble and one control bit on each clock edge, pairs the falling-edge capture with the rising-edge capture before it, and hands the byte to the MAC one rising edge later in the receive clock domain.

A single speed input chooses between byte mode, used at 1000 Mbps with a 125 MHz clock, and nibble mode, used at 100 and 10 Mbps with 25 MHz and 2.5 MHz clocks. In nibble mode each clock carries one nibble, repeated on both edges on transmit. On receive the bridge packs two successive nibbles into a byte, the first one as the low half, and marks each completed byte with a one-cycle valid strobe. The speed input is treated as static configuration and is changed only while both resets are held. Clock generation and skew delays stay outside the block. So does any decoding of link status sent in band.

Top module: `ddr_gmii_bridge`

## Requirements
- R1: A rising edge with the domain's active-low reset low clears that domain's outputs to zero: `ddr_txd` and `ddr_tx_ctl` in both clock phases, and `gmii_rxd`, `gmii_rx_dv` and `gmii_rx_er`, whatever the inputs do.
- R2: In byte mode (`spd_gig` = 1), a byte sampled on `gmii_txd` at rising edge k drives its bits [3:0] on `ddr_txd` from edge k to the next falling edge. Its bits [7:4] follow from that falling edge to edge k+1.
- R3: In both modes `ddr_tx_ctl` carries the `gmii_tx_en` sampled at edge k while the clock is high after k. It carries the `gmii_tx_er` sampled at edge k while the clock is low after k.
- R4: In nibble mode (`spd_gig` = 0), `gmii_txd[3:0]` sampled at edge k appears on `ddr_txd` in both phases after k, and `gmii_txd[7:4]` has no effect.
- R5: In byte mode, the nibble on `ddr_rxd` at rising edge p becomes `gmii_rxd[3:0]`, and the nibble at the following falling edge becomes `gmii_rxd[7:4]`. Both are presented after rising edge p+1.
- R6: In byte mode, `ddr_rx_ctl` at rising edge p becomes `gmii_rx_dv`, and `ddr_rx_ctl` at the following falling edge becomes `gmii_rx_er`. Both take the same timing as R5.
- R7: In nibble mode, two successive rising edges p-1 and p with `ddr_rx_ctl` high form one byte. The nibble at p-1 becomes bits [3:0] and the nibble at p becomes bits [7:4]. The byte appears on `gmii_rxd` with `gmii_rx_dv` high for the single cycle after edge p+1.
- R8: In nibble mode, `gmii_rx_er` on a completed byte is the OR of the falling-edge control bits of its two nibbles. When no byte completes, `gmii_rxd` and `gmii_rx_er` are zero, and falling-edge data nibbles have no effect.
- R9: In nibble mode, a rising edge with `ddr_rx_ctl` low discards any unpaired nibble, and the next nibble with the control bit high starts a new byte as its low half.
- R10: In nibble mode `gmii_rx_dv` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock; both edges used |
| tx_rst_n | input | 1 | Transmit-domain synchronous reset, active low |
| rx_clk | input | 1 | Receive clock; both edges used |
| rx_rst_n | input | 1 | Receive-domain synchronous reset, active low |
| spd_gig | input | 1 | 1 = byte mode (1000 Mbps), 0 = nibble mode (10/100 Mbps) |
| gmii_txd | input | 8 | Transmit byte from the MAC |
| gmii_tx_en | input | 1 | Transmit enable from the MAC |
| gmii_tx_er | input | 1 | Transmit error from the MAC |
| ddr_txd | output | 4 | Double-rate transmit nibble to the PHY |
| ddr_tx_ctl | output | 1 | Transmit control wire: enable when high, error when low |
| ddr_rxd | input | 4 | Double-rate receive nibble from the PHY |
| ddr_rx_ctl | input | 1 | Receive control wire: valid on rising edge, error on falling edge |
| gmii_rxd | output | 8 | Receive byte to the MAC |
| gmii_rx_dv | output | 1 | Receive data valid (one-cycle strobe per byte in nibble mode) |
| gmii_rx_er | output | 1 | Receive error to the MAC |

## Verification
The embedded properties check on every cycle that the falling-edge transmit register shows the byte held for that clock period. They also check that in nibble mode both transmit phases carry the same nibble, and that in byte mode the receive low nibble and valid bit are the port values from two rising edges earlier. In nibble mode they check that every receive strobe rests on two successive valid nibbles and is never repeated in the next cycle. The high-nibble path through the falling edge, the error-bit placement and the realignment after odd-length receive runs can only be shown by the bench's scenarios. So can the clearing on a reset applied after traffic. There, a behavioural model compares both clock phases of the transmit wires and the receive byte on every clock.

// File: rtl/ddr_gmii_pkg.sv
// Shared widths and types for the double-rate media interface bridge.
// Assumes a nibble lane of NIB_W bits and a MAC byte of two nibbles.
package ddr_gmii_pkg;

    localparam int unsigned NIB_W  = 4;
    localparam int unsigned BYTE_W = 2 * NIB_W;
    localparam int unsigned LANE_W = NIB_W + 1;   // nibble plus control wire

    // Link speed class selected by configuration.
    typedef enum logic {
        SPD_NIBBLE = 1'b0,   // 10/100: one nibble per clock
        SPD_BYTE   = 1'b1    // 1000: one byte per clock, both edges
    } spd_e;

    // One MAC-side beat: a byte with its two qualifier bits.
    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              flag_a;  // enable / valid
        logic              flag_b;  // error
    } beat_t;

endpackage

// File: rtl/ddr_tx_oddr.sv
// Double-edge output stage: one register per edge per lane, with the
// clock level choosing which register drives the pin.
// Assumes rise_d is settled at each rising edge and fall_d stays stable
// from the rising edge through the following falling edge.
module ddr_tx_oddr #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_d,
    input  logic [W-1:0] fall_d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic r_q;
        logic f_q;

        // Rising-edge half: captures the value shown while the clock is high.
        always_ff @(posedge clk) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= rise_d[i];
        end

        // Falling-edge half: captures the value shown while the clock is low.
        always_ff @(negedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= fall_d[i];
        end

        assign q[i]      = clk ? r_q : f_q;
        assign rise_o[i] = r_q;
        assign fall_o[i] = f_q;
    end

    // R2: the falling-edge register must hold the source that stayed
    // stable across the whole period, not a later or earlier one.
    oddr_fall_hold_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fall_o == fall_d)
    );

endmodule

// File: rtl/ddr_gmii_tx.sv
// Transmit direction: samples the MAC byte on the rising edge, holds it
// for a full period, and splits it over both edges of the output stage.
// Assumes spd changes only while rst_n is low.
module ddr_gmii_tx
    import ddr_gmii_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  spd_e              spd,
    input  logic [BYTE_W-1:0] txd,
    input  logic              tx_en,
    input  logic              tx_er,
    output logic [NIB_W-1:0]  ddr_d,
    output logic              ddr_ctl
);

    beat_t             hold_q;
    logic [LANE_W-1:0] rise_vec;
    logic [LANE_W-1:0] fall_vec;
    logic [LANE_W-1:0] pin_vec;
    logic [LANE_W-1:0] rise_seen;
    logic [LANE_W-1:0] fall_seen;
    logic [NIB_W-1:0]  fall_nib;

    // Holding register: keeps the byte of this period for the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= '{data: txd, flag_a: tx_en, flag_b: tx_er};
    end

    // Falling-half nibble: upper half in byte mode, repeated lower half otherwise.
    always_comb begin
        if (spd == SPD_BYTE) fall_nib = hold_q.data[BYTE_W-1:NIB_W];
        else                 fall_nib = hold_q.data[NIB_W-1:0];
    end

    assign rise_vec = {tx_en, txd[NIB_W-1:0]};
    assign fall_vec = {hold_q.flag_b, fall_nib};

    ddr_tx_oddr #(.W(LANE_W)) u_oddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_d (rise_vec),
        .fall_d (fall_vec),
        .q      (pin_vec),
        .rise_o (rise_seen),
        .fall_o (fall_seen)
    );

    assign ddr_d   = pin_vec[NIB_W-1:0];
    assign ddr_ctl = pin_vec[NIB_W];

    // R4: in nibble mode both halves of a period carry the same nibble.
    tx_nibble_repeat_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && spd == SPD_NIBBLE && $stable(spd))
            |-> (rise_seen[NIB_W-1:0] == fall_seen[NIB_W-1:0])
    );

endmodule

// File: rtl/ddr_iddr.sv
// Double-edge input capture: one register per edge per lane.
// Assumes input setup is met around both clock edges.
module ddr_iddr #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    for (genvar i = 0; i < W; i++) begin : g_lane
        logic r_q;
        logic f_q;

        // Rising-edge capture of the pin.
        always_ff @(posedge clk) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= d[i];
        end

        // Falling-edge capture of the pin.
        always_ff @(negedge clk) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= d[i];
        end

        assign rise_o[i] = r_q;
        assign fall_o[i] = f_q;
    end

endmodule

// File: rtl/nibble_packer.sv
// Nibble-mode receive assembly: pairs two successive valid nibbles into
// a byte, first one low, and emits a one-cycle strobe per byte.
// Assumes one nibble offered per clock with its valid and error bits.
module nibble_packer #(
    parameter int unsigned NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [NW-1:0] nib,
    input  logic          nib_dv,
    input  logic          nib_er,
    output logic [2*NW-1:0] byte_o,
    output logic          strobe_o,
    output logic          err_o
);

    logic          have_q;
    logic [NW-1:0] low_q;
    logic          low_er_q;

    // Pairing state machine: store a low half, then complete or discard.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            have_q   <= 1'b0;
            low_q    <= '0;
            low_er_q <= 1'b0;
            byte_o   <= '0;
            strobe_o <= 1'b0;
            err_o    <= 1'b0;
        end else if (!nib_dv) begin
            have_q   <= 1'b0;
            byte_o   <= '0;
            strobe_o <= 1'b0;
            err_o    <= 1'b0;
        end else if (!have_q) begin
            have_q   <= 1'b1;
            low_q    <= nib;
            low_er_q <= nib_er;
            byte_o   <= '0;
            strobe_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            have_q   <= 1'b0;
            byte_o   <= {nib, low_q};
            strobe_o <= 1'b1;
            err_o    <= low_er_q | nib_er;
        end
    end

    // R10
    pk_strobe_gap_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        (en && $past(en) && strobe_o) |=> !strobe_o
    );

endmodule

// File: rtl/ddr_gmii_rx.sv
// Receive direction: captures both edges, forms a byte per clock in
// byte mode or per two clocks in nibble mode, and re-registers it on
// the rising edge of the receive clock.
// Assumes spd changes only while rst_n is low.
module ddr_gmii_rx
    import ddr_gmii_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  spd_e              spd,
    input  logic [NIB_W-1:0]  ddr_d,
    input  logic              ddr_ctl,
    output logic [BYTE_W-1:0] rxd,
    output logic              rx_dv,
    output logic              rx_er
);

    logic [LANE_W-1:0] rise_cap;
    logic [LANE_W-1:0] fall_cap;
    beat_t             wide_q;
    logic [BYTE_W-1:0] pk_byte;
    logic              pk_stb;
    logic              pk_err;
    logic              nib_en;

    ddr_iddr #(.W(LANE_W)) u_iddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      ({ddr_ctl, ddr_d}),
        .rise_o (rise_cap),
        .fall_o (fall_cap)
    );

    // Byte-mode join: falling capture above the rising capture before it.
    always_ff @(posedge clk) begin
        if (!rst_n || spd != SPD_BYTE) begin
            wide_q <= '0;
        end else begin
            wide_q <= '{data:   {fall_cap[NIB_W-1:0], rise_cap[NIB_W-1:0]},
                        flag_a: rise_cap[NIB_W],
                        flag_b: fall_cap[NIB_W]};
        end
    end

    assign nib_en = (spd == SPD_NIBBLE);

    nibble_packer #(.NW(NIB_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (nib_en),
        .nib      (rise_cap[NIB_W-1:0]),
        .nib_dv   (rise_cap[NIB_W]),
        .nib_er   (fall_cap[NIB_W]),
        .byte_o   (pk_byte),
        .strobe_o (pk_stb),
        .err_o    (pk_err)
    );

    // Output select between the two registered paths by speed class.
    always_comb begin
        if (spd == SPD_BYTE) begin
            rxd   = wide_q.data;
            rx_dv = wide_q.flag_a;
            rx_er = wide_q.flag_b;
        end else begin
            rxd   = pk_byte;
            rx_dv = pk_stb;
            rx_er = pk_err;
        end
    end

    // R5 and R6: byte-mode low nibble and valid lag the pins by two edges.
    rx_byte_low_lag_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && spd == SPD_BYTE &&
         $past(spd) == SPD_BYTE && $past(spd, 2) == SPD_BYTE)
            |-> (rxd[NIB_W-1:0] == $past(ddr_d, 2) && rx_dv == $past(ddr_ctl, 2))
    );

    // R7: a nibble-mode strobe rests on two successive valid nibbles.
    rx_pair_dv_chk: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3) &&
         spd == SPD_NIBBLE && $past(spd) == SPD_NIBBLE &&
         $past(spd, 2) == SPD_NIBBLE && $past(spd, 3) == SPD_NIBBLE && rx_dv)
            |-> ($past(ddr_ctl, 2) && $past(ddr_ctl, 3))
    );

endmodule

// File: rtl/ddr_gmii_bridge.sv
// Top level: byte-wide MAC interface to a double-rate nibble interface,
// one direction per clock domain.
// Assumes spd_gig is static while either domain is out of reset.
module ddr_gmii_bridge
    import ddr_gmii_pkg::*;
(
    input  logic              tx_clk,
    input  logic              tx_rst_n,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              spd_gig,
    input  logic [BYTE_W-1:0] gmii_txd,
    input  logic              gmii_tx_en,
    input  logic              gmii_tx_er,
    output logic [NIB_W-1:0]  ddr_txd,
    output logic              ddr_tx_ctl,
    input  logic [NIB_W-1:0]  ddr_rxd,
    input  logic              ddr_rx_ctl,
    output logic [BYTE_W-1:0] gmii_rxd,
    output logic              gmii_rx_dv,
    output logic              gmii_rx_er
);

    spd_e spd_w;

    assign spd_w = spd_gig ? SPD_BYTE : SPD_NIBBLE;

    ddr_gmii_tx u_tx (
        .clk     (tx_clk),
        .rst_n   (tx_rst_n),
        .spd     (spd_w),
        .txd     (gmii_txd),
        .tx_en   (gmii_tx_en),
        .tx_er   (gmii_tx_er),
        .ddr_d   (ddr_txd),
        .ddr_ctl (ddr_tx_ctl)
    );

    ddr_gmii_rx u_rx (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .spd     (spd_w),
        .ddr_d   (ddr_rxd),
        .ddr_ctl (ddr_rx_ctl),
        .rxd     (gmii_rxd),
        .rx_dv   (gmii_rx_dv),
        .rx_er   (gmii_rx_er)
    );

endmodule

// File: tb/ddr_gmii_bridge_tb.sv
// Bench: behavioural reference for both directions, compared each clock
// in both clock phases.
module ddr_gmii_bridge_tb;

    typedef struct packed {
        logic [3:0] lo;
        logic [3:0] hi;
        logic       dv;
        logic       er;
    } rb_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic       rst_n = 1'b0;
    logic       spd_gig = 1'b1;
    logic [7:0] gmii_txd = '0;
    logic       gmii_tx_en = 1'b0;
    logic       gmii_tx_er = 1'b0;
    logic [3:0] ddr_txd;
    logic       ddr_tx_ctl;
    logic [3:0] ddr_rxd = '0;
    logic       ddr_rx_ctl = 1'b0;
    logic [7:0] gmii_rxd;
    logic       gmii_rx_dv;
    logic       gmii_rx_er;

    ddr_gmii_bridge u_dut (
        .tx_clk     (clk),
        .tx_rst_n   (rst_n),
        .rx_clk     (clk),
        .rx_rst_n   (rst_n),
        .spd_gig    (spd_gig),
        .gmii_txd   (gmii_txd),
        .gmii_tx_en (gmii_tx_en),
        .gmii_tx_er (gmii_tx_er),
        .ddr_txd    (ddr_txd),
        .ddr_tx_ctl (ddr_tx_ctl),
        .ddr_rxd    (ddr_rxd),
        .ddr_rx_ctl (ddr_rx_ctl),
        .gmii_rxd   (gmii_rxd),
        .gmii_rx_dv (gmii_rx_dv),
        .gmii_rx_er (gmii_rx_er)
    );

    int unsigned n_cmp = 0;
    int unsigned n_bad = 0;
    int unsigned cyc   = 0;
    int unsigned seed  = 32'h1234_5678;

    // Transmit model state: value driven now and value seen at last edge.
    logic [7:0] t_d, c_d;
    logic       t_en, t_er, c_en, c_er;
    // Receive model state.
    rb_t        rb_prev, rb_cur, rb_nxt;
    bit         m_have;
    logic [3:0] m_low;
    logic       m_low_er;
    logic       last_dv;

    function automatic logic [31:0] nxt_rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as one failed check and still summarises.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog R1..: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Hold reset with busy inputs, check cleared outputs (R1), then release.
    task automatic reset_phase(input logic mode);
        @(posedge clk);
        #2;
        rst_n      = 1'b0;
        spd_gig    = mode;
        gmii_txd   = 8'hA5;
        gmii_tx_en = 1'b1;
        gmii_tx_er = 1'b1;
        ddr_rxd    = 4'hF;
        ddr_rx_ctl = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 tx nibble high phase", {12'h0, ddr_txd}, 16'h0);
        chk("R1 tx ctl high phase", {15'h0, ddr_tx_ctl}, 16'h0);
        chk("R1 rx byte", {8'h0, gmii_rxd}, 16'h0);
        chk("R1 rx dv", {15'h0, gmii_rx_dv}, 16'h0);
        chk("R1 rx er", {15'h0, gmii_rx_er}, 16'h0);
        #10;
        chk("R1 tx nibble low phase", {12'h0, ddr_txd}, 16'h0);
        chk("R1 tx ctl low phase", {15'h0, ddr_tx_ctl}, 16'h0);
        @(posedge clk);
        #2;
        rst_n      = 1'b1;
        gmii_txd   = '0;
        gmii_tx_en = 1'b0;
        gmii_tx_er = 1'b0;
        ddr_rxd    = '0;
        ddr_rx_ctl = 1'b0;
        t_d = '0; t_en = 1'b0; t_er = 1'b0;
        rb_cur = '0; rb_nxt = '0;
        m_have = 1'b0; m_low = '0; m_low_er = 1'b0;
        last_dv = 1'b0;
    endtask

    task automatic run(input int n_cyc, input logic mode);
        logic [31:0] r;
        logic [7:0]  e_d;
        logic        e_dv, e_er;
        for (int m = 0; m < n_cyc; m++) begin
            @(posedge clk);
            c_d = t_d; c_en = t_en; c_er = t_er;
            rb_prev = rb_cur;
            rb_cur  = rb_nxt;
            #2;
            r = nxt_rnd();
            t_d  = r[7:0];
            t_en = r[9];
            t_er = (r[14:12] == 3'd0);
            gmii_txd   = t_d;
            gmii_tx_en = t_en;
            gmii_tx_er = t_er;
            #3;
            // High phase of transmit (R2, R3, R4).
            if (mode) chk("R2 tx low nibble in high phase", {12'h0, ddr_txd}, {12'h0, c_d[3:0]});
            else      chk("R4 tx nibble in high phase", {12'h0, ddr_txd}, {12'h0, c_d[3:0]});
            chk("R3 tx ctl carries enable", {15'h0, ddr_tx_ctl}, {15'h0, c_en});
            // Receive reference for the beat captured one edge earlier.
            if (mode) begin
                e_d = {rb_prev.hi, rb_prev.lo}; e_dv = rb_prev.dv; e_er = rb_prev.er;
                chk("R5 rx byte from both edges", {8'h0, gmii_rxd}, {8'h0, e_d});
                chk("R6 rx valid from rising ctl", {15'h0, gmii_rx_dv}, {15'h0, e_dv});
                chk("R6 rx error from falling ctl", {15'h0, gmii_rx_er}, {15'h0, e_er});
            end else begin
                if (!rb_prev.dv) begin
                    m_have = 1'b0; e_d = '0; e_dv = 1'b0; e_er = 1'b0;
                end else if (!m_have) begin
                    m_have = 1'b1; m_low = rb_prev.lo; m_low_er = rb_prev.er;
                    e_d = '0; e_dv = 1'b0; e_er = 1'b0;
                end else begin
                    m_have = 1'b0; e_d = {rb_prev.lo, m_low};
                    e_dv = 1'b1; e_er = m_low_er | rb_prev.er;
                end
                chk("R7 rx nibble pair byte", {8'h0, gmii_rxd}, {8'h0, e_d});
                chk("R9 rx strobe alignment", {15'h0, gmii_rx_dv}, {15'h0, e_dv});
                chk("R8 rx combined error", {15'h0, gmii_rx_er}, {15'h0, e_er});
                chk("R10 no back-to-back strobe", {15'h0, gmii_rx_dv & last_dv}, 16'h0);
                last_dv = gmii_rx_dv;
            end
            ddr_rxd    = rb_cur.hi;
            ddr_rx_ctl = rb_cur.er;
            #10;
            // Low phase of transmit.
            if (mode) chk("R2 tx high nibble in low phase", {12'h0, ddr_txd}, {12'h0, c_d[7:4]});
            else      chk("R4 tx repeated nibble in low phase", {12'h0, ddr_txd}, {12'h0, c_d[3:0]});
            chk("R3 tx ctl carries error", {15'h0, ddr_tx_ctl}, {15'h0, c_er});
            // Next receive beat: odd-length valid runs in nibble mode.
            r = nxt_rnd();
            rb_nxt.lo = r[3:0];
            rb_nxt.hi = r[7:4];
            rb_nxt.er = (r[12:10] == 3'd0);
            if (mode) rb_nxt.dv = r[15];
            else      rb_nxt.dv = ((m % 13) < 7) || ((m % 13) == 9) || ((m % 29) == 11);
            ddr_rxd    = rb_nxt.lo;
            ddr_rx_ctl = rb_nxt.dv;
        end
    endtask

    initial begin
        reset_phase(1'b1);
        run(500, 1'b1);
        reset_phase(1'b0);
        run(600, 1'b0);
        reset_phase(1'b1);
        run(100, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule